// File: doc/BRIEF.md
# Storage-Card Host Idle Handshake and Clock Autogating Controller

This block decides when the interface and functional clocks of a storage-card host controller may be switched off. It does this in two ways. The first is automatic gating during normal operation. When the automatic-idle enable is set, the block counts consecutive quiet cycles. A quiet cycle is one with no card-bus activity and no wake event. After a configurable number of quiet cycles it drops both clock enables. The enables come back in the cycle after a register access, a card wake interrupt, the start of a transfer, or renewed bus activity.

The second way is the reply to a system power manager's idle request. A two-bit idle-mode field selects how the block answers. It can acknowledge every request, ignore every request, or acknowledge only when no transfer is in progress and no wake event is pending. While the acknowledge is high the block is in idle mode and both clock enables are held low. Normal mode and idle mode therefore never overlap.

Top module: `pm_idle_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, ifc_clk_en_o and fn_clk_en_o are 1 and idle_ack_o is 0.
- R2: With autoidle_i at 1, the clock enables fall at the GATE_DELAY-th (default 4) consecutive rising edge at which the cycle is quiet. A cycle is quiet when bus_busy_i, reg_access_i, card_wake_i and xfer_start_i are all 0.
- R3: With autoidle_i at 0, automatic gating never starts.
- R4: A non-quiet cycle before the quiet count completes restarts the count from zero.
- R5: While gated, a cycle with reg_access_i, card_wake_i, xfer_start_i or bus_busy_i at 1 makes both enables 1 again after the next rising edge, provided idle_ack_o is 0.
- R6: While gated, clearing autoidle_i alone does not bring the enables back.
- R7: idle_mode_i = 0 (force): idle_ack_o is 1 in the cycle after any cycle with idle_req_i at 1, whatever the bus or wake activity.
- R8: idle_mode_i = 1 (no idle) and the reserved value 3 never raise idle_ack_o, and gating behaves as if no request were present.
- R9: idle_mode_i = 2 (smart): idle_ack_o is 1 in the cycle after a cycle with idle_req_i at 1, bus_busy_i at 0 and no wake event. Otherwise it is 0 in the next cycle, which also withdraws it one edge after the request falls or activity appears.
- R10: Whenever idle_ack_o is 1, both clock enables are 0. When the acknowledge drops and the block is not gated, the enables return in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| autoidle_i | input | 1 | Automatic clock-gating enable |
| idle_mode_i | input | 2 | Idle answer mode: 0 force, 1 never, 2 smart, 3 reserved (never) |
| idle_req_i | input | 1 | Idle request from the system power manager |
| reg_access_i | input | 1 | Register access strobe from the interconnect |
| card_wake_i | input | 1 | Card wake interrupt |
| xfer_start_i | input | 1 | Card-bus transfer start pulse |
| bus_busy_i | input | 1 | Card-bus transaction in progress |
| ifc_clk_en_o | output | 1 | Interface clock enable |
| fn_clk_en_o | output | 1 | Functional clock enable |
| idle_ack_o | output | 1 | Idle acknowledge to the power manager |

## Verification
Every state bit reaches the ports one edge after the inputs that set it. A wrong quiet count, a gate flag stuck high, or an acknowledge decoded from the wrong mode therefore shows as an enable or acknowledge that differs from the cycle-level expectation within one clock. The bench predicts all three outputs on every cycle and covers each idle mode with and without bus activity. It also covers gating interrupted mid-count, and release by each wake source separately. A fault therefore appears at the first cycle where that path decides the output.

// File: rtl/pm_idle_pkg.sv
package pm_idle_pkg;
  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NEVER = 2'd1,
    IDLE_SMART = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_mode_e;

  localparam int unsigned N_WAKE_SRC = 3;
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             wake_o
);
  logic [N_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | src_i[i];
  end
  assign wake_o = chain[N_SRC];
endmodule

// File: rtl/pm_autogate.sv
module pm_autogate #(
  parameter int unsigned GATE_DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic autoidle_i,
  input  logic bus_busy_i,
  input  logic wake_i,
  output logic gated_o
);
  localparam int unsigned DLY   = (GATE_DELAY < 1) ? 1 : GATE_DELAY;
  localparam int unsigned CNT_W = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY - 1);

  logic             gated_q;
  logic [CNT_W-1:0] cnt_q;
  logic             quiet, release_evt;

  assign quiet       = autoidle_i & ~bus_busy_i & ~wake_i;
  assign release_evt = wake_i | bus_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gated_q <= 1'b0;
      cnt_q   <= '0;
    end else if (gated_q) begin
      cnt_q <= '0;
      // autoidle drop alone keeps gating; only activity releases
      if (release_evt) gated_q <= 1'b0;
    end else if (!quiet) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      gated_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gated_o = gated_q;
endmodule

// File: rtl/pm_idle_ack.sv
module pm_idle_ack
  import pm_idle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] idle_mode_i,
  input  logic       idle_req_i,
  input  logic       bus_busy_i,
  input  logic       wake_i,
  output logic       ack_o
);
  idle_mode_e mode;
  logic       ack_d, ack_q;

  assign mode = idle_mode_e'(idle_mode_i);

  always_comb begin
    ack_d = 1'b0;
    unique case (mode)
      IDLE_FORCE: ack_d = idle_req_i;
      IDLE_SMART: ack_d = idle_req_i & ~bus_busy_i & ~wake_i;
      IDLE_NEVER,
      IDLE_RSVD:  ack_d = 1'b0;
      default:    ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_d;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
  import pm_idle_pkg::*;
#(
  parameter int unsigned GATE_DELAY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       autoidle_i,
  input  logic [1:0] idle_mode_i,
  input  logic       idle_req_i,
  input  logic       reg_access_i,
  input  logic       card_wake_i,
  input  logic       xfer_start_i,
  input  logic       bus_busy_i,
  output logic       ifc_clk_en_o,
  output logic       fn_clk_en_o,
  output logic       idle_ack_o
);
  logic [N_WAKE_SRC-1:0] wake_src;
  logic wake, gated, ack, run;

  assign wake_src = {xfer_start_i, card_wake_i, reg_access_i};

  pm_wake_detect #(.N_SRC(N_WAKE_SRC)) u_wake (
    .src_i  (wake_src),
    .wake_o (wake)
  );

  pm_autogate #(.GATE_DELAY(GATE_DELAY)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .autoidle_i (autoidle_i),
    .bus_busy_i (bus_busy_i),
    .wake_i     (wake),
    .gated_o    (gated)
  );

  pm_idle_ack u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_mode_i (idle_mode_i),
    .idle_req_i  (idle_req_i),
    .bus_busy_i  (bus_busy_i),
    .wake_i      (wake),
    .ack_o       (ack)
  );

  // normal and idle mode are exclusive: ack forces clocks off
  assign run          = ~gated & ~ack;
  assign ifc_clk_en_o = run;
  assign fn_clk_en_o  = run;
  assign idle_ack_o   = ack;
endmodule

// File: rtl/pm_idle_ctrl_chk.sv
module pm_idle_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       autoidle_i,
  input logic [1:0] idle_mode_i,
  input logic       idle_req_i,
  input logic       reg_access_i,
  input logic       card_wake_i,
  input logic       xfer_start_i,
  input logic       bus_busy_i,
  input logic       ifc_clk_en_o,
  input logic       fn_clk_en_o,
  input logic       idle_ack_o
);
  logic evt;
  assign evt = reg_access_i | card_wake_i | xfer_start_i;

  AST_GATE_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fn_clk_en_o) && !idle_ack_o) |-> $past(autoidle_i && !bus_busy_i)); // R2

  AST_NO_AUTOIDLE_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!autoidle_i && fn_clk_en_o && !idle_mode_i[1] && idle_mode_i[0]) |=> fn_clk_en_o); // R3

  AST_WAKE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fn_clk_en_o && !idle_ack_o && (evt || bus_busy_i) && idle_mode_i == 2'd1) |=> fn_clk_en_o); // R5

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fn_clk_en_o && !idle_ack_o && !evt && !bus_busy_i) |=> !fn_clk_en_o); // R6

  AST_FORCE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_i == 2'd0 && idle_req_i) |=> idle_ack_o); // R7

  AST_NEVER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_i[0]) |=> !idle_ack_o); // R8

  AST_SMART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_i == 2'd2 && (bus_busy_i || evt || !idle_req_i)) |=> !idle_ack_o); // R9

  AST_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_ack_o) |-> (!ifc_clk_en_o && !fn_clk_en_o)); // R10
endmodule

bind pm_idle_ctrl pm_idle_ctrl_chk u_chk (.*);

// File: tb/pm_idle_ctrl_tb.sv
module pm_idle_ctrl_tb;
  localparam int unsigned D = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       autoidle_i = 1'b0;
  logic [1:0] idle_mode_i = 2'd1;
  logic       idle_req_i = 1'b0;
  logic       reg_access_i = 1'b0;
  logic       card_wake_i = 1'b0;
  logic       xfer_start_i = 1'b0;
  logic       bus_busy_i = 1'b0;
  logic       ifc_clk_en_o, fn_clk_en_o, idle_ack_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  pm_idle_ctrl #(.GATE_DELAY(D)) u_dut (.*);

  typedef struct {
    logic  en;
    logic  ack;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // reference state
  bit m_g = 0;
  int m_cnt = 0;
  bit m_ack = 0;

  // drive one cycle and predict outputs after the next edge
  task automatic cyc(input bit ai, input bit [1:0] md, input bit rq,
                     input bit ra, input bit cw, input bit xs, input bit bb,
                     input string tag);
    bit evt, quiet;
    exp_t e;
    @(negedge clk_i);
    autoidle_i = ai; idle_mode_i = md; idle_req_i = rq;
    reg_access_i = ra; card_wake_i = cw; xfer_start_i = xs; bus_busy_i = bb;
    evt   = ra | cw | xs;
    quiet = ai & !bb & !evt;
    if (m_g) begin
      if (evt | bb) m_g = 0;
      m_cnt = 0;
    end else if (!quiet) m_cnt = 0;
    else if (m_cnt == D - 1) begin m_g = 1; m_cnt = 0; end
    else m_cnt++;
    m_ack = rq && (md == 2'd0 || (md == 2'd2 && !bb && !evt));
    e.en = !m_g && !m_ack; e.ack = m_ack; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle_n(input int n, input bit ai, input string tag);
    for (int i = 0; i < n; i++) cyc(ai, 2'd1, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (ifc_clk_en_o !== e.en || fn_clk_en_o !== e.en || idle_ack_o !== e.ack) begin
        errors++;
        $display("FAIL %s: ifc=%b fn=%b ack=%b expected en=%b ack=%b",
                 e.tag, ifc_clk_en_o, fn_clk_en_o, idle_ack_o, e.en, e.ack);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    checks++; // R1 during reset
    if (ifc_clk_en_o !== 1'b1 || fn_clk_en_o !== 1'b1 || idle_ack_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: ifc=%b fn=%b ack=%b expected 1 1 0", ifc_clk_en_o, fn_clk_en_o, idle_ack_o);
    end
    rst_ni = 1'b1;
    idle_n(2, 0, "R1");
    idle_n(8, 0, "R3");
    idle_n(6, 1, "R2");
    cyc(1, 2'd1, 0, 1, 0, 0, 0, "R5 reg_access");
    idle_n(5, 1, "R2");
    cyc(1, 2'd1, 0, 0, 1, 0, 0, "R5 card_wake");
    idle_n(5, 1, "R2");
    cyc(1, 2'd1, 0, 0, 0, 1, 0, "R5 xfer_start");
    idle_n(5, 1, "R2");
    cyc(1, 2'd1, 0, 0, 0, 0, 1, "R5 bus_busy");
    idle_n(5, 1, "R2");
    idle_n(4, 0, "R6");
    cyc(0, 2'd1, 0, 1, 0, 0, 0, "R6 release");
    idle_n(2, 0, "R3");
    idle_n(3, 1, "R4");
    cyc(1, 2'd1, 0, 0, 0, 0, 1, "R4 busy");
    idle_n(3, 1, "R4");
    cyc(1, 2'd1, 0, 0, 1, 0, 0, "R4 wake");
    idle_n(3, 1, "R4");
    idle_n(2, 1, "R4");
    cyc(0, 2'd1, 0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 2'd0, 1, 0, 0, 0, 1, "R7 busy");
    cyc(0, 2'd0, 1, 1, 1, 1, 0, "R7 wake");
    cyc(0, 2'd0, 0, 0, 0, 0, 0, "R10 drop");
    cyc(0, 2'd0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) cyc(0, 2'd1, 1, 0, 0, 0, 0, "R8 never");
    for (int i = 0; i < 4; i++) cyc(0, 2'd3, 1, 0, 0, 0, 0, "R8 reserved");
    for (int i = 0; i < 5; i++) cyc(1, 2'd1, 1, 0, 0, 0, 0, "R8 gating");
    cyc(1, 2'd1, 1, 1, 0, 0, 0, "R5");
    cyc(0, 2'd2, 1, 0, 0, 0, 1, "R9 busy");
    cyc(0, 2'd2, 1, 0, 0, 0, 1, "R9 busy");
    cyc(0, 2'd2, 1, 0, 0, 0, 0, "R9 ack");
    cyc(0, 2'd2, 1, 0, 0, 0, 0, "R10");
    cyc(0, 2'd2, 1, 0, 1, 0, 0, "R9 wake");
    cyc(0, 2'd2, 1, 0, 0, 0, 0, "R9 ack");
    cyc(0, 2'd2, 0, 0, 0, 0, 0, "R9 req fall");
    cyc(0, 2'd2, 0, 0, 0, 0, 0, "R10");
    idle_n(5, 1, "R2");
    cyc(1, 2'd2, 1, 0, 0, 0, 0, "R10 gated ack");
    cyc(1, 2'd2, 0, 0, 0, 0, 0, "R10 gated");
    cyc(1, 2'd1, 0, 1, 0, 0, 0, "R5");
    idle_n(2, 0, "R3");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule